// File: doc/BRIEF.md
# Autonegotiation Result Validator with Bounded Retry

This block sits beside an Ethernet PHY and judges, each time autonegotiation claims to be complete, whether the link-partner ability word can be believed. The PHY can report completion while that word is wrong in two ways. In an early failure the base page was never really exchanged. In a late failure the word looks plausible but does not match what the partner advertised. The block detects both. It uses a status bit taken from a normally hidden register bank, and a missing-acknowledge heuristic drawn from the expansion and ability words.

When the result looks corrupt, the block emits a one-cycle restart request, counts the attempt and waits for the done flag to drop and return before it judges again. A good result raises an accept flag and clears the count. After a bounded number of restarts, a further corrupt result raises a sticky give-up flag, and no more restarts are issued. With autonegotiation disabled, the block is transparent: the done flag passes to the accept flag and no check is made.

Top module: `aneg_guard`

## Requirements
- R1: With `an_enable_i` low, `accept_o` equals the `an_done_i` value of the previous cycle, `restart_o` stays low and `retry_cnt_o` reads 0.
- R2: With enable high, a rise of done while bit 12 of `hidden_stat_i` is 0 is judged corrupt. One cycle later `restart_o` pulses instead of `accept_o` rising.
- R3: With enable high, done high and bit 12 of `hidden_stat_i` set, the result is corrupt exactly when bit 0 of `expansion_i` (partner can negotiate) is 1 and bit 14 of `lp_ability_i` (partner acknowledge) is 0. With bit 0 of `expansion_i` at 0, a missing acknowledge is accepted.
- R4: `restart_o` is high for exactly one cycle. No further check is made until done has been seen low and then high again.
- R5: `retry_cnt_o` is 0 after reset and rises by one in the same cycle as each `restart_o` pulse. It never exceeds MAX_RETRY (default 6).
- R6: A corrupt result seen while the count is at MAX_RETRY sets `give_up_o` and issues no restart. `give_up_o` stays set until reset, and `restart_o` stays low while it is set.
- R7: A good result sets `accept_o` one cycle later and clears `retry_cnt_o`. `accept_o` holds until the cycle after done falls.
- R8: Dropping `an_enable_i` clears `retry_cnt_o` on the next edge, and any pending wait is abandoned.
- R9: `early_o` pulses together with `restart_o` when the rejected ability word equals 0x0001. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| an_enable_i | input | 1 | Autonegotiation enabled |
| an_done_i | input | 1 | PHY reports negotiation complete |
| lp_ability_i | input | 16 | Link-partner ability word |
| expansion_i | input | 16 | Autonegotiation expansion word |
| hidden_stat_i | input | 16 | Hidden-bank status word (bit 12 = result good) |
| restart_o | output | 1 | One-cycle restart-negotiation request |
| accept_o | output | 1 | Negotiation result accepted |
| early_o | output | 1 | Rejected result matched the early-failure pattern |
| retry_cnt_o | output | CNT_W (3) | Restarts issued since last good result |
| give_up_o | output | 1 | Sticky: retry budget exhausted |

## Verification
The validator is tried with four kinds of result: a clean one, one with the hidden status bit clear, one with a negotiation-capable partner and no acknowledge, and one with no acknowledge but a partner that cannot negotiate. Between them they separate the two corruption causes from each other and from the harmless missing-acknowledge case. Long runs of corrupt results, with done held high across a restart, check that each completion is judged only once and that the count stops at its limit before the give-up flag is set. Enable drops, a good result after give-up and a mid-run reset confirm which state each event clears and which state persists.

// File: rtl/aneg_guard_pkg.sv
package aneg_guard_pkg;
  typedef enum logic [1:0] {
    ST_WATCH     = 2'd0,
    ST_HOLD      = 2'd1,
    ST_WAIT_FALL = 2'd2
  } guard_state_e;
endpackage

// File: rtl/aneg_guard_check.sv
module aneg_guard_check #(
  parameter int          WORD_W     = 16,
  parameter int          STAT_BIT   = 12,
  parameter int          ACK_BIT    = 14,
  parameter int          NWAY_BIT   = 0,
  parameter logic [15:0] EARLY_CODE = 16'h0001
) (
  input  logic [WORD_W-1:0] lp_ability_i,
  input  logic [WORD_W-1:0] expansion_i,
  input  logic [WORD_W-1:0] hidden_stat_i,
  output logic              corrupt_o,
  output logic              early_pat_o
);
  logic stat_bad, ack_missing;

  assign stat_bad    = ~hidden_stat_i[STAT_BIT];
  assign ack_missing = expansion_i[NWAY_BIT] & ~lp_ability_i[ACK_BIT];
  assign corrupt_o   = stat_bad | ack_missing;
  assign early_pat_o = (lp_ability_i == EARLY_CODE[WORD_W-1:0]);
endmodule

// File: rtl/aneg_guard_retry.sv
module aneg_guard_retry #(
  parameter int MAX_RETRY = 6,
  localparam int CNT_W    = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             set_give_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o,
  output logic             give_up_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] cnt_q;
  logic             give_q;

  assign at_max_o  = (cnt_q == CntMax);
  assign cnt_o     = cnt_q;
  assign give_up_o = give_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !at_max_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         give_q <= 1'b0;
    else if (set_give_i) give_q <= 1'b1;
  end
endmodule

// File: rtl/aneg_guard_fsm.sv
module aneg_guard_fsm
  import aneg_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  input  logic corrupt_i,
  input  logic early_pat_i,
  input  logic at_max_i,
  input  logic give_up_i,
  output logic restart_o,
  output logic early_o,
  output logic accept_o,
  output logic inc_o,
  output logic clr_o,
  output logic set_give_o
);
  guard_state_e state_q, state_d;
  logic restart_d, early_d, accept_d;
  logic restart_q, early_q, accept_q;

  always_comb begin
    state_d    = state_q;
    restart_d  = 1'b0;
    early_d    = 1'b0;
    accept_d   = accept_q;
    inc_o      = 1'b0;
    clr_o      = 1'b0;
    set_give_o = 1'b0;
    if (!en_i) begin
      // transparent: no checking, budget reset
      state_d  = ST_WATCH;
      clr_o    = 1'b1;
      accept_d = done_i;
    end else begin
      unique case (state_q)
        ST_WATCH: begin
          accept_d = 1'b0;
          if (done_i) begin
            if (!corrupt_i) begin
              accept_d = 1'b1;
              clr_o    = 1'b1;
              state_d  = ST_HOLD;
            end else if (give_up_i || at_max_i) begin
              set_give_o = 1'b1;
              state_d    = ST_HOLD;
            end else begin
              restart_d = 1'b1;
              early_d   = early_pat_i;
              inc_o     = 1'b1;
              state_d   = ST_WAIT_FALL;
            end
          end
        end
        ST_HOLD: begin
          if (!done_i) begin
            accept_d = 1'b0;
            state_d  = ST_WATCH;
          end
        end
        ST_WAIT_FALL: begin
          accept_d = 1'b0;
          if (!done_i) state_d = ST_WATCH;
        end
        default: state_d = ST_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WATCH;
      restart_q <= 1'b0;
      early_q   <= 1'b0;
      accept_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
      early_q   <= early_d;
      accept_q  <= accept_d;
    end
  end

  assign restart_o = restart_q;
  assign early_o   = early_q;
  assign accept_o  = accept_q;
endmodule

// File: rtl/aneg_guard.sv
module aneg_guard #(
  parameter int  WORD_W    = 16,
  parameter int  MAX_RETRY = 6,
  localparam int CNT_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              an_enable_i,
  input  logic              an_done_i,
  input  logic [WORD_W-1:0] lp_ability_i,
  input  logic [WORD_W-1:0] expansion_i,
  input  logic [WORD_W-1:0] hidden_stat_i,
  output logic              restart_o,
  output logic              accept_o,
  output logic              early_o,
  output logic [CNT_W-1:0]  retry_cnt_o,
  output logic              give_up_o
);
  logic corrupt, early_pat, at_max, inc, clr, set_give;

  aneg_guard_check #(.WORD_W(WORD_W)) u_check (
    .lp_ability_i (lp_ability_i),
    .expansion_i  (expansion_i),
    .hidden_stat_i(hidden_stat_i),
    .corrupt_o    (corrupt),
    .early_pat_o  (early_pat)
  );

  aneg_guard_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (an_enable_i),
    .done_i     (an_done_i),
    .corrupt_i  (corrupt),
    .early_pat_i(early_pat),
    .at_max_i   (at_max),
    .give_up_i  (give_up_o),
    .restart_o  (restart_o),
    .early_o    (early_o),
    .accept_o   (accept_o),
    .inc_o      (inc),
    .clr_o      (clr),
    .set_give_o (set_give)
  );

  aneg_guard_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .clr_i     (clr),
    .set_give_i(set_give),
    .cnt_o     (retry_cnt_o),
    .at_max_o  (at_max),
    .give_up_o (give_up_o)
  );
endmodule

// File: rtl/aneg_guard_sva.sv
module aneg_guard_sva #(
  parameter int CNT_W     = 3,
  parameter int MAX_RETRY = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             an_enable_i,
  input logic             restart_o,
  input logic             early_o,
  input logic [CNT_W-1:0] retry_cnt_o,
  input logic             give_up_o
);
  AST_NO_RESTART_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_enable_i |=> !restart_o); // R1
  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= CNT_W'(MAX_RETRY)); // R5
  AST_RESTART_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> retry_cnt_o != '0); // R5
  AST_GIVE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_up_o |=> give_up_o); // R6
  AST_NO_RESTART_GIVEN_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_up_o |-> !restart_o); // R6
  AST_EARLY_WITH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> restart_o); // R9
  AST_ENABLE_DROP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_enable_i |=> retry_cnt_o == '0); // R8
endmodule

bind aneg_guard aneg_guard_sva #(.CNT_W(CNT_W), .MAX_RETRY(MAX_RETRY)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .an_enable_i(an_enable_i),
  .restart_o  (restart_o),
  .early_o    (early_o),
  .retry_cnt_o(retry_cnt_o),
  .give_up_o  (give_up_o)
);

// File: tb/test_aneg_guard.sv
module test_aneg_guard;
  localparam int MAXR = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, done = 1'b0;
  logic [15:0] lp = '0, ex = '0, hs = '0;
  logic        restart, accept, early, give;
  logic [2:0]  cnt;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int m_mode = 0; // 0 watch, 1 hold, 2 wait-for-fall
  int m_cnt = 0;
  bit m_restart = 0, m_accept = 0, m_early = 0, m_give = 0;

  always #2.5 clk = ~clk;

  aneg_guard i_aneg_guard (
    .clk_i(clk), .rst_ni(rst_n), .an_enable_i(en), .an_done_i(done),
    .lp_ability_i(lp), .expansion_i(ex), .hidden_stat_i(hs),
    .restart_o(restart), .accept_o(accept), .early_o(early),
    .retry_cnt_o(cnt), .give_up_o(give)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R7 accept", accept, m_accept);
    chk("R4 restart", restart, m_restart);
    chk("R5 count", cnt, m_cnt);
    chk("R6 give_up", give, m_give);
    chk("R9 early", early, m_early);
  endtask

  function automatic bit bad_result(logic [15:0] l, logic [15:0] e, logic [15:0] h);
    return !h[12] || (e[0] && !l[14]);
  endfunction

  task automatic cyc(bit e, bit d, logic [15:0] l, logic [15:0] x, logic [15:0] h);
    en = e; done = d; lp = l; ex = x; hs = h;
    m_restart = 0; m_early = 0;
    if (!e) begin
      m_mode = 0; m_cnt = 0; m_accept = d;
    end else if (m_mode == 0) begin
      m_accept = 0;
      if (d) begin
        if (!bad_result(l, x, h)) begin
          m_accept = 1; m_cnt = 0; m_mode = 1;
        end else if (m_give || m_cnt == MAXR) begin
          m_give = 1; m_mode = 1;
        end else begin
          m_restart = 1; m_early = (l == 16'h0001); m_cnt++; m_mode = 2;
        end
      end
    end else if (m_mode == 1) begin
      if (!d) begin m_accept = 0; m_mode = 0; end
    end else begin
      m_accept = 0;
      if (!d) m_mode = 0;
    end
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  localparam logic [15:0] LP_GOOD = 16'h45E1; // ack bit 14 set
  localparam logic [15:0] LP_NOACK = 16'h05E1;
  localparam logic [15:0] HS_OK = 16'h1000, HS_BAD = 16'h0000;

  task automatic corrupt_round(logic [15:0] l);
    cyc(1, 1, l, 16'h0001, HS_BAD);
    cyc(1, 1, l, 16'h0001, HS_BAD);
    cyc(1, 0, l, 16'h0001, HS_BAD);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    compare_all(); // reset state
    chk("R5 reset count", cnt, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0);
    // R1: disabled, corrupt words ignored, done passes through
    cyc(0, 1, 16'h0001, 16'h0001, HS_BAD);
    chk("R1 passthrough", accept, 1);
    chk("R1 no restart", restart, 0);
    cyc(0, 0, 16'h0001, 16'h0001, HS_BAD);
    chk("R1 passthrough low", accept, 0);
    // R7: good result
    cyc(1, 0, LP_GOOD, 16'h0001, HS_OK);
    cyc(1, 1, LP_GOOD, 16'h0001, HS_OK);
    chk("R7 accept", accept, 1);
    cyc(1, 1, LP_GOOD, 16'h0001, HS_OK);
    cyc(1, 0, LP_GOOD, 16'h0001, HS_OK);
    chk("R7 drop", accept, 0);
    // R2: hidden status clear, early pattern (R9)
    cyc(1, 1, 16'h0001, 16'h0000, HS_BAD);
    chk("R2 restart", restart, 1);
    chk("R9 early", early, 1);
    chk("R5 count one", cnt, 1);
    // R4: done held high, no second check
    cyc(1, 1, LP_GOOD, 16'h0000, HS_BAD);
    chk("R4 one pulse", restart, 0);
    cyc(1, 1, LP_GOOD, 16'h0000, HS_OK);
    chk("R4 no recheck", accept, 0);
    cyc(1, 0, LP_GOOD, 16'h0000, HS_OK);
    cyc(1, 1, LP_GOOD, 16'h0000, HS_OK);
    chk("R7 accept after retry", accept, 1);
    chk("R7 count cleared", cnt, 0);
    cyc(1, 0, LP_GOOD, 0, HS_OK);
    // R3: partner can negotiate, ack missing
    cyc(1, 1, LP_NOACK, 16'h0001, HS_OK);
    chk("R3 restart", restart, 1);
    chk("R9 no early", early, 0);
    cyc(1, 0, LP_NOACK, 16'h0001, HS_OK);
    // R3: partner cannot negotiate, missing ack accepted
    cyc(1, 1, LP_NOACK, 16'h0000, HS_OK);
    chk("R3 accept", accept, 1);
    chk("R3 no restart", restart, 0);
    cyc(1, 0, LP_NOACK, 16'h0000, HS_OK);
    // R8: enable drop clears count
    for (int i = 0; i < 3; i++) corrupt_round(16'h0001);
    chk("R8 count before", cnt, 3);
    cyc(1, 1, LP_NOACK, 16'h0001, HS_OK);
    cyc(0, 1, LP_NOACK, 16'h0001, HS_OK);
    chk("R8 count cleared", cnt, 0);
    cyc(0, 0, 0, 0, HS_OK);
    // R6: exhaust budget
    for (int i = 0; i < MAXR; i++) corrupt_round(LP_NOACK);
    chk("R5 saturate", cnt, MAXR);
    cyc(1, 1, LP_NOACK, 16'h0001, HS_BAD);
    chk("R6 give up", give, 1);
    chk("R6 no restart", restart, 0);
    cyc(1, 0, LP_NOACK, 16'h0001, HS_BAD);
    cyc(1, 1, LP_NOACK, 16'h0001, HS_BAD);
    chk("R6 still no restart", restart, 0);
    cyc(1, 0, LP_GOOD, 0, HS_OK);
    cyc(1, 1, LP_GOOD, 0, HS_OK);
    chk("R7 accept after give up", accept, 1);
    chk("R6 sticky", give, 1);
    cyc(1, 0, LP_GOOD, 0, HS_OK);
    // reset clears give-up
    rst_n = 1'b0;
    m_mode = 0; m_cnt = 0; m_restart = 0; m_accept = 0; m_early = 0; m_give = 0;
    @(negedge clk);
    compare_all();
    chk("R6 reset clears", give, 0);
    rst_n = 1'b1;
    corrupt_round(16'h0001);
    chk("R5 count after reset", cnt, 1);
    finish_run();
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
      finish_run();
    end
  end
endmodule